// File: doc/BRIEF.md
# Interrupt Controller Programming Sequencer

This block is the register front end of a single eight-line interrupt controller core. It accepts byte writes and reads at two addresses, walks through the multi-word initialization sequence, and decodes the operation commands written at the first address. It also chooses which core register a read returns.

The result is a set of configuration fields and one-cycle strobes that a separate priority core uses: the line mask, the vector base, the automatic-end-of-interrupt and nesting modes, end-of-interrupt requests with their line, priority-rotation requests, and a pending poll request. The core supplies its request and in-service bytes and a poll code, and the block returns them on reads. Priority resolution is done by the core.

Top module: `irq_prog_seq`

## Requirements
- R1: After reset all outputs are 0, the sequencer is in its normal state (`init_busy`=0), and an address-1 read returns 0.
- R2: A write at address 0 with bit 4 = 1 is a start word. It clears the mask, vector base, auto-EOI, nesting, rotate-on-auto-EOI, special mask, read select and pending poll, and pulses `core_clear` in the next cycle. It also latches bit 0 as "mode word needed" and bit 1 as "single controller", and sets `init_busy`.
- R3: The first address-1 write after a start word loads bits 7:3 into `vec_base`. The sequencer then goes to the cascade-word step if not single. If single, it goes to the mode-word step when a mode word is needed, and otherwise back to normal.
- R4: In the cascade-word step an address-1 write changes no field. The sequencer goes on to the mode-word step if one is needed, and otherwise to normal. Address-1 writes during initialization never change `mask_val`.
- R5: The mode word sets `nest_mode` from bit 4 and `auto_eoi` from bit 1, then returns to normal (`init_busy`=0).
- R6: In the normal state an address-1 write loads `mask_val` with the data byte.
- R7: A write at address 0 with bits 4:3 = 01 is a read/poll command. Bit 2 = 1 arms a poll. Bit 1 = 1 loads the read select from bit 0 (1 = in-service). Bit 6 = 1 loads `spec_mask` from bit 5.
- R8: A write at address 0 with bits 4:3 = 00 and bits 7:5 = 0 clears `rot_aeoi`. Bits 7:5 = 4 sets it.
- R9: With bits 4:3 = 00, bits 7:5 = 1, 5, 3 and 7 give non-specific EOI, rotating non-specific EOI, specific EOI and rotating specific EOI. Each gives a one-cycle `eoi_stb` in the next cycle, with `eoi_specific` and `eoi_rotate` set to match. `eoi_line` is bits 2:0 for the specific forms and 0 for the others.
- R10: Bits 7:5 = 6 (with bits 4:3 = 00) gives a one-cycle `prio_stb` with `prio_line` = bits 2:0, naming the line that becomes lowest priority. Bits 7:5 = 2 changes no output.
- R11: With no poll pending, a read returns `mask_val` at address 1. At address 0 it returns `svc_bits` if the read select is 1 and `req_bits` otherwise. `rd_data` is combinational.
- R12: With a poll pending, a read at either address returns `poll_code`, clears `poll_req` and pulses `poll_taken` in the next cycle. If a poll command is written in the same cycle as that read, the poll stays pending.
- R13: `lvl_err` takes bit 3 of each start word and holds it until the next start word. The bit has no other effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_sel | input | 1 | Address bit: 0 = command port, 1 = data port |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wr_data | input | 8 | Write data byte |
| req_bits | input | 8 | Request register from the core |
| svc_bits | input | 8 | In-service register from the core |
| poll_code | input | 8 | Poll result from the core |
| rd_data | output | 8 | Read data (combinational) |
| mask_val | output | 8 | Line mask |
| vec_base | output | 5 | Vector base, upper five bits |
| auto_eoi | output | 1 | Automatic EOI mode |
| nest_mode | output | 1 | Special fully nested mode |
| rot_aeoi | output | 1 | Rotate on automatic EOI |
| spec_mask | output | 1 | Special mask mode |
| core_clear | output | 1 | One-cycle core state clear after a start word |
| init_busy | output | 1 | Initialization sequence in progress |
| lvl_err | output | 1 | Unsupported level-trigger request seen |
| eoi_stb | output | 1 | EOI command strobe |
| eoi_specific | output | 1 | EOI names a line |
| eoi_rotate | output | 1 | EOI also rotates priority |
| eoi_line | output | 3 | Line for a specific EOI |
| prio_stb | output | 1 | Priority set strobe |
| prio_line | output | 3 | Line made lowest priority |
| poll_req | output | 1 | Poll pending |
| poll_taken | output | 1 | One-cycle pulse: a read consumed the poll |

## Verification
A read that consumes a pending poll can fall in the same cycle as a write that arms a new poll. The bench provokes this with a directed read plus poll-command write, and it also mixes random reads with address-0 writes. It expects the read to return the core's poll code, `poll_taken` to pulse, and `poll_req` to stay high; a following plain read must then clear it. A start word can likewise meet a consuming read, and there the clear of the poll by the start word must win.

// File: rtl/irq_prog_pkg.sv
// Shared types for the interrupt programming sequencer.
// Assumes an eight-line core and byte-wide programming writes.
package irq_prog_pkg;

    // Steps of the initialization word sequence
    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_BASE = 2'd1,
        ST_CASC = 2'd2,
        ST_MODE = 2'd3
    } init_st_e;

    // Operation codes carried in bits 7:5 of a command-port write
    typedef enum logic [2:0] {
        OP_ROT_CLR    = 3'd0,
        OP_EOI_NS     = 3'd1,
        OP_NOP        = 3'd2,
        OP_EOI_SP     = 3'd3,
        OP_ROT_SET    = 3'd4,
        OP_EOI_NS_ROT = 3'd5,
        OP_PRIO       = 3'd6,
        OP_EOI_SP_ROT = 3'd7
    } op_code_e;

endpackage

// File: rtl/irq_wr_decode.sv
// Classifies one programming write into exactly one word kind.
// Assumes bits 4:3 of a command-port write select the kind.
module irq_wr_decode (
    input  logic       addr_sel,
    input  logic       wr_en,
    input  logic [1:0] kind_bits,
    output logic       init_word,
    output logic       rdcmd_word,
    output logic       opcmd_word,
    output logic       port1_word
);
    // Word kind decode
    always_comb begin
        init_word  = wr_en && !addr_sel && kind_bits[1];
        rdcmd_word = wr_en && !addr_sel && !kind_bits[1] && kind_bits[0];
        opcmd_word = wr_en && !addr_sel && (kind_bits == 2'b00);
        port1_word = wr_en && addr_sel;
    end
endmodule

// File: rtl/irq_init_seq.sv
// Initialization word sequencer and data-port register owner.
// Holds mask, vector base, mode bits and the level-trigger flag.
// Assumes at most one word kind is flagged per cycle.
module irq_init_seq
    import irq_prog_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int LINE_W = $clog2(DATA_W),
    localparam int BASE_W = DATA_W - LINE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_word,
    input  logic              port1_word,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] mask_val,
    output logic [BASE_W-1:0] vec_base,
    output logic              auto_eoi,
    output logic              nest_mode,
    output logic              core_clear,
    output logic              init_busy,
    output logic              lvl_err
);
    init_st_e state_q;
    logic     need_mode_q;
    logic     single_q;
    logic     unused_bit2;

    assign unused_bit2 = wr_data[2];
    assign init_busy   = (state_q != ST_RUN);

    // Sequence step, configuration fields and start-word side effects
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_RUN;
            need_mode_q <= 1'b0;
            single_q    <= 1'b0;
            mask_val    <= '0;
            vec_base    <= '0;
            auto_eoi    <= 1'b0;
            nest_mode   <= 1'b0;
            core_clear  <= 1'b0;
            lvl_err     <= 1'b0;
        end else begin
            core_clear <= init_word;
            if (init_word) begin
                state_q     <= ST_BASE;
                need_mode_q <= wr_data[0];
                single_q    <= wr_data[1];
                lvl_err     <= wr_data[3];
                mask_val    <= '0;
                vec_base    <= '0;
                auto_eoi    <= 1'b0;
                nest_mode   <= 1'b0;
            end else if (port1_word) begin
                unique case (state_q)
                    ST_RUN:  mask_val <= wr_data;
                    ST_BASE: begin
                        vec_base <= wr_data[DATA_W-1:LINE_W];
                        if (!single_q)       state_q <= ST_CASC;
                        else if (need_mode_q) state_q <= ST_MODE;
                        else                  state_q <= ST_RUN;
                    end
                    ST_CASC: state_q <= need_mode_q ? ST_MODE : ST_RUN;
                    ST_MODE: begin
                        nest_mode <= wr_data[4];
                        auto_eoi  <= wr_data[1];
                        state_q   <= ST_RUN;
                    end
                    default: state_q <= ST_RUN;
                endcase
            end
        end
    end

    // R2: a start word clears the core and the mask one cycle later
    p_start_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        init_word |=> (core_clear && init_busy && mask_val == '0));

    // R4: data-port writes during the sequence leave the mask alone
    p_mask_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (init_busy && port1_word) |=> $stable(mask_val));

    // R5: the mode word always ends the sequence
    p_mode_ends_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MODE && port1_word && !init_word) |=> !init_busy);

    // R6: a data-port write in normal state lands in the mask
    p_mask_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_busy && port1_word) |=> (mask_val == $past(wr_data)));
endmodule

// File: rtl/irq_cmd_regs.sv
// Operation and read/poll command decoder.
// Keeps read select, special mask, rotate-on-auto-EOI and the poll flag,
// and issues one-cycle EOI and priority strobes.
// Assumes the start word has priority over every other update.
module irq_cmd_regs
    import irq_prog_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int LINE_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_word,
    input  logic              rdcmd_word,
    input  logic              opcmd_word,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              rot_aeoi,
    output logic              spec_mask,
    output logic              rd_isr_sel,
    output logic              poll_req,
    output logic              poll_taken,
    output logic              eoi_stb,
    output logic              eoi_specific,
    output logic              eoi_rotate,
    output logic [LINE_W-1:0] eoi_line,
    output logic              prio_stb,
    output logic [LINE_W-1:0] prio_line
);
    op_code_e    op;
    logic [1:0]  unused_kind;

    assign op          = op_code_e'(wr_data[7:5]);
    assign unused_kind = wr_data[4:3];

    // Mode flags and poll flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rot_aeoi   <= 1'b0;
            spec_mask  <= 1'b0;
            rd_isr_sel <= 1'b0;
            poll_req   <= 1'b0;
            poll_taken <= 1'b0;
        end else begin
            poll_taken <= rd_en && poll_req;
            if (init_word) begin
                rot_aeoi   <= 1'b0;
                spec_mask  <= 1'b0;
                rd_isr_sel <= 1'b0;
                poll_req   <= 1'b0;
            end else begin
                if (rd_en && poll_req)
                    poll_req <= 1'b0;
                if (rdcmd_word) begin
                    if (wr_data[2]) poll_req   <= 1'b1;
                    if (wr_data[1]) rd_isr_sel <= wr_data[0];
                    if (wr_data[6]) spec_mask  <= wr_data[5];
                end
                if (opcmd_word && op == OP_ROT_CLR) rot_aeoi <= 1'b0;
                if (opcmd_word && op == OP_ROT_SET) rot_aeoi <= 1'b1;
            end
        end
    end

    // One-cycle EOI and priority strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eoi_stb      <= 1'b0;
            eoi_specific <= 1'b0;
            eoi_rotate   <= 1'b0;
            eoi_line     <= '0;
            prio_stb     <= 1'b0;
            prio_line    <= '0;
        end else begin
            eoi_stb      <= 1'b0;
            eoi_specific <= 1'b0;
            eoi_rotate   <= 1'b0;
            eoi_line     <= '0;
            prio_stb     <= 1'b0;
            prio_line    <= '0;
            if (opcmd_word) begin
                case (op)
                    OP_EOI_NS: eoi_stb <= 1'b1;
                    OP_EOI_NS_ROT: begin
                        eoi_stb    <= 1'b1;
                        eoi_rotate <= 1'b1;
                    end
                    OP_EOI_SP: begin
                        eoi_stb      <= 1'b1;
                        eoi_specific <= 1'b1;
                        eoi_line     <= wr_data[LINE_W-1:0];
                    end
                    OP_EOI_SP_ROT: begin
                        eoi_stb      <= 1'b1;
                        eoi_specific <= 1'b1;
                        eoi_rotate   <= 1'b1;
                        eoi_line     <= wr_data[LINE_W-1:0];
                    end
                    OP_PRIO: begin
                        prio_stb  <= 1'b1;
                        prio_line <= wr_data[LINE_W-1:0];
                    end
                    default: ;
                endcase
            end
        end
    end

    // R9/R10: never an EOI and a priority set at once
    p_one_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({eoi_stb, prio_stb}));

    // R10: the reserved opcode leaves both strobes low
    p_nop_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (opcmd_word && op == OP_NOP) |=> (!eoi_stb && !prio_stb));

    // R12: a read with nothing else written consumes the poll
    p_poll_consumed_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && poll_req) |=> (!poll_req && poll_taken));

    // R7: a poll command arms the flag unless a start word is written
    p_poll_armed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rdcmd_word && wr_data[2]) |=> poll_req);
endmodule

// File: rtl/irq_rd_steer.sv
// Read data selection: poll code, mask, in-service or request byte.
// Assumes the poll flag has precedence over the address.
module irq_rd_steer #(
    parameter int DATA_W = 8
) (
    input  logic              addr_sel,
    input  logic              poll_req,
    input  logic              rd_isr_sel,
    input  logic [DATA_W-1:0] poll_code,
    input  logic [DATA_W-1:0] mask_val,
    input  logic [DATA_W-1:0] svc_bits,
    input  logic [DATA_W-1:0] req_bits,
    output logic [DATA_W-1:0] rd_data
);
    // Read multiplexer
    always_comb begin
        if (poll_req)       rd_data = poll_code;
        else if (addr_sel)  rd_data = mask_val;
        else if (rd_isr_sel) rd_data = svc_bits;
        else                rd_data = req_bits;
    end
endmodule

// File: rtl/irq_prog_seq.sv
// Top of the interrupt programming sequencer: decodes two-address byte
// accesses into configuration fields and strobes for a priority core.
// Assumes one access per cycle; a read may share a cycle with a write.
module irq_prog_seq #(
    parameter int DATA_W = 8,
    localparam int LINE_W = $clog2(DATA_W),
    localparam int BASE_W = DATA_W - LINE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_sel,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] req_bits,
    input  logic [DATA_W-1:0] svc_bits,
    input  logic [DATA_W-1:0] poll_code,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] mask_val,
    output logic [BASE_W-1:0] vec_base,
    output logic              auto_eoi,
    output logic              nest_mode,
    output logic              rot_aeoi,
    output logic              spec_mask,
    output logic              core_clear,
    output logic              init_busy,
    output logic              lvl_err,
    output logic              eoi_stb,
    output logic              eoi_specific,
    output logic              eoi_rotate,
    output logic [LINE_W-1:0] eoi_line,
    output logic              prio_stb,
    output logic [LINE_W-1:0] prio_line,
    output logic              poll_req,
    output logic              poll_taken
);
    logic init_word, rdcmd_word, opcmd_word, port1_word;
    logic rd_isr_sel;

    irq_wr_decode u_dec (
        .addr_sel   (addr_sel),
        .wr_en      (wr_en),
        .kind_bits  (wr_data[4:3]),
        .init_word  (init_word),
        .rdcmd_word (rdcmd_word),
        .opcmd_word (opcmd_word),
        .port1_word (port1_word)
    );

    irq_init_seq #(.DATA_W(DATA_W)) u_init (
        .clk        (clk),
        .rst_n      (rst_n),
        .init_word  (init_word),
        .port1_word (port1_word),
        .wr_data    (wr_data),
        .mask_val   (mask_val),
        .vec_base   (vec_base),
        .auto_eoi   (auto_eoi),
        .nest_mode  (nest_mode),
        .core_clear (core_clear),
        .init_busy  (init_busy),
        .lvl_err    (lvl_err)
    );

    irq_cmd_regs #(.DATA_W(DATA_W)) u_cmd (
        .clk          (clk),
        .rst_n        (rst_n),
        .init_word    (init_word),
        .rdcmd_word   (rdcmd_word),
        .opcmd_word   (opcmd_word),
        .rd_en        (rd_en),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .rot_aeoi     (rot_aeoi),
        .spec_mask    (spec_mask),
        .rd_isr_sel   (rd_isr_sel),
        .poll_req     (poll_req),
        .poll_taken   (poll_taken),
        .eoi_stb      (eoi_stb),
        .eoi_specific (eoi_specific),
        .eoi_rotate   (eoi_rotate),
        .eoi_line     (eoi_line),
        .prio_stb     (prio_stb),
        .prio_line    (prio_line)
    );

    irq_rd_steer #(.DATA_W(DATA_W)) u_rd (
        .addr_sel   (addr_sel),
        .poll_req   (poll_req),
        .rd_isr_sel (rd_isr_sel),
        .poll_code  (poll_code),
        .mask_val   (mask_val),
        .svc_bits   (svc_bits),
        .req_bits   (req_bits),
        .rd_data    (rd_data)
    );

    // R11: with no poll pending, a data-port read returns the mask
    p_rd_mask_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr_sel && !poll_req) |-> (rd_data == mask_val));

    // R13: the level flag follows bit 3 of the last start word
    p_lvl_flag_r13: assert property (@(posedge clk) disable iff (!rst_n)
        init_word |=> (lvl_err == $past(wr_data[3])));
endmodule

// File: tb/irq_prog_seq_test.sv
module irq_prog_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic addr_sel = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wr_data = '0, req_bits = '0, svc_bits = '0, poll_code = '0;
    logic [7:0] rd_data, mask_val;
    logic [4:0] vec_base;
    logic auto_eoi, nest_mode, rot_aeoi, spec_mask, core_clear, init_busy, lvl_err;
    logic eoi_stb, eoi_specific, eoi_rotate, prio_stb, poll_req, poll_taken;
    logic [2:0] eoi_line, prio_line;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 0;

    // reference model state
    int   m_st;          // 0 run, 1 base, 2 cascade, 3 mode
    bit   m_need4, m_single, m_aeoi, m_nest, m_rot, m_smm, m_rsel, m_poll, m_lerr;
    bit   m_clr, m_eoi, m_sp, m_ro, m_prio, m_ptk;
    logic [7:0] m_mask;
    logic [4:0] m_base;
    logic [2:0] m_eline, m_pline;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_prog_seq uut (
        .clk(clk), .rst_n(rst_n), .addr_sel(addr_sel), .wr_en(wr_en), .rd_en(rd_en),
        .wr_data(wr_data), .req_bits(req_bits), .svc_bits(svc_bits), .poll_code(poll_code),
        .rd_data(rd_data), .mask_val(mask_val), .vec_base(vec_base), .auto_eoi(auto_eoi),
        .nest_mode(nest_mode), .rot_aeoi(rot_aeoi), .spec_mask(spec_mask),
        .core_clear(core_clear), .init_busy(init_busy), .lvl_err(lvl_err),
        .eoi_stb(eoi_stb), .eoi_specific(eoi_specific), .eoi_rotate(eoi_rotate),
        .eoi_line(eoi_line), .prio_stb(prio_stb), .prio_line(prio_line),
        .poll_req(poll_req), .poll_taken(poll_taken)
    );

    task automatic chk(string what, logic [7:0] got, logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", what, got, exp);
        end
    endtask

    task automatic model_reset();
        m_st = 0; m_need4 = 0; m_single = 0; m_aeoi = 0; m_nest = 0; m_rot = 0;
        m_smm = 0; m_rsel = 0; m_poll = 0; m_lerr = 0; m_mask = 0; m_base = 0;
        m_clr = 0; m_eoi = 0; m_sp = 0; m_ro = 0; m_prio = 0; m_ptk = 0;
        m_eline = 0; m_pline = 0;
    endtask

    function automatic logic [7:0] exp_rd(bit a);
        if (m_poll) return poll_code;
        if (a) return m_mask;
        return m_rsel ? svc_bits : req_bits;
    endfunction

    // next state of the model from the requirements
    task automatic model_step(bit wr, bit rd, bit a, logic [7:0] d);
        m_clr = 0; m_eoi = 0; m_sp = 0; m_ro = 0; m_prio = 0; m_eline = 0; m_pline = 0;
        m_ptk = rd && m_poll;
        if (rd && m_poll) m_poll = 0;
        if (wr && !a && d[4]) begin
            m_st = 1; m_need4 = d[0]; m_single = d[1]; m_lerr = d[3]; m_clr = 1;
            m_mask = 0; m_base = 0; m_aeoi = 0; m_nest = 0; m_rot = 0; m_smm = 0;
            m_rsel = 0; m_poll = 0;
        end else if (wr && !a && d[3]) begin
            if (d[2]) m_poll = 1;
            if (d[1]) m_rsel = d[0];
            if (d[6]) m_smm = d[5];
        end else if (wr && !a) begin
            case (d[7:5])
                3'd0: m_rot = 0;
                3'd4: m_rot = 1;
                3'd1: m_eoi = 1;
                3'd5: begin m_eoi = 1; m_ro = 1; end
                3'd3: begin m_eoi = 1; m_sp = 1; m_eline = d[2:0]; end
                3'd7: begin m_eoi = 1; m_sp = 1; m_ro = 1; m_eline = d[2:0]; end
                3'd6: begin m_prio = 1; m_pline = d[2:0]; end
                default: ;
            endcase
        end else if (wr && a) begin
            case (m_st)
                0: m_mask = d;
                1: begin
                    m_base = d[7:3];
                    m_st = !m_single ? 2 : (m_need4 ? 3 : 0);
                end
                2: m_st = m_need4 ? 3 : 0;
                default: begin m_nest = d[4]; m_aeoi = d[1]; m_st = 0; end
            endcase
        end
    endtask

    task automatic check_all();
        chk("R6 mask_val", mask_val, m_mask);
        chk("R3 vec_base", {3'b0, vec_base}, {3'b0, m_base});
        chk("R3 init_busy", {7'b0, init_busy}, {7'b0, m_st != 0});
        chk("R5 nest_mode", {7'b0, nest_mode}, {7'b0, m_nest});
        chk("R5 auto_eoi", {7'b0, auto_eoi}, {7'b0, m_aeoi});
        chk("R8 rot_aeoi", {7'b0, rot_aeoi}, {7'b0, m_rot});
        chk("R7 spec_mask", {7'b0, spec_mask}, {7'b0, m_smm});
        chk("R2 core_clear", {7'b0, core_clear}, {7'b0, m_clr});
        chk("R13 lvl_err", {7'b0, lvl_err}, {7'b0, m_lerr});
        chk("R9 eoi", {4'b0, eoi_stb, eoi_specific, eoi_rotate, 1'b0}, {4'b0, m_eoi, m_sp, m_ro, 1'b0});
        chk("R9 eoi_line", {5'b0, eoi_line}, {5'b0, m_eline});
        chk("R10 prio", {4'b0, prio_stb, prio_line}, {4'b0, m_prio, m_pline});
        chk("R12 poll_req", {7'b0, poll_req}, {7'b0, m_poll});
        chk("R12 poll_taken", {7'b0, poll_taken}, {7'b0, m_ptk});
    endtask

    // one access cycle, starting and ending at a falling edge
    task automatic step(bit wr, bit rd, bit a, logic [7:0] d);
        wr_en = wr; rd_en = rd; addr_sel = a; wr_data = d;
        req_bits = 8'($urandom); svc_bits = 8'($urandom); poll_code = 8'($urandom);
        #1;
        if (rd) chk(m_poll ? "R12 poll read" : "R11 read data", rd_data, exp_rd(a));
        model_step(wr, rd, a, d);
        @(posedge clk);
        @(negedge clk);
        wr_en = 0; rd_en = 0;
        check_all();
    endtask

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG && !done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog: got %0d cycles expected under %0d", cyc, WATCHDOG);
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        check_all();
        addr_sel = 1; #1;
        chk("R1 reset read", rd_data, 8'h00);
        chk("R1 reset busy", {7'b0, init_busy}, 8'h00);

        // R6 mask load, then R2 start word clears it
        step(1, 0, 1, 8'h5A);
        step(1, 0, 0, 8'h19);                       // cascaded, mode word needed, level flag
        chk("R2 mask cleared", mask_val, 8'h00);
        chk("R2 core_clear pulse", {7'b0, core_clear}, 8'h01);
        chk("R13 level flag", {7'b0, lvl_err}, 8'h01);
        step(1, 0, 1, 8'hA8);                       // base
        chk("R3 base", {3'b0, vec_base}, 8'h15);
        step(1, 0, 1, 8'hFF);                       // cascade word ignored
        chk("R4 mask unchanged", mask_val, 8'h00);
        chk("R4 still busy", {7'b0, init_busy}, 8'h01);
        step(1, 0, 1, 8'h12);                       // mode word
        chk("R5 nest", {7'b0, nest_mode}, 8'h01);
        chk("R5 aeoi", {7'b0, auto_eoi}, 8'h01);
        chk("R5 done", {7'b0, init_busy}, 8'h00);

        // R3 single-controller paths
        step(1, 0, 0, 8'h12); step(1, 0, 1, 8'h40);
        chk("R3 single no mode word", {7'b0, init_busy}, 8'h00);
        step(1, 0, 0, 8'h13); step(1, 0, 1, 8'h40);
        chk("R3 single to mode step", {7'b0, init_busy}, 8'h01);
        step(1, 0, 1, 8'h00);
        step(1, 0, 0, 8'h10); step(1, 0, 1, 8'h08); step(1, 0, 1, 8'h00);
        chk("R4 cascade to normal", {7'b0, init_busy}, 8'h00);
        chk("R13 flag cleared", {7'b0, lvl_err}, 8'h00);

        // R8 / R9 / R10 commands
        for (int k = 0; k < 8; k++) step(1, 0, 0, {3'(k), 5'b00101});
        step(1, 0, 0, 8'h80);
        chk("R8 rot set", {7'b0, rot_aeoi}, 8'h01);
        step(1, 0, 0, 8'h44);                       // reserved opcode
        chk("R10 reserved no strobe", {6'b0, eoi_stb, prio_stb}, 8'h00);

        // R7 / R11 read select and R12 poll collisions
        step(1, 0, 0, 8'h0B); step(0, 1, 0, 8'h00);
        step(1, 0, 0, 8'h0A); step(0, 1, 0, 8'h00);
        step(1, 0, 0, 8'h0C);
        step(1, 1, 0, 8'h0C);
        chk("R12 poll kept on same-cycle rearm", {7'b0, poll_req}, 8'h01);
        step(0, 1, 1, 8'h00);
        chk("R12 poll cleared", {7'b0, poll_req}, 8'h00);
        step(1, 0, 0, 8'h0C);
        step(1, 1, 0, 8'h10);                       // start word wins over read
        chk("R2 start clears poll", {7'b0, poll_req}, 8'h00);
        step(1, 0, 1, 8'h00); step(1, 0, 1, 8'h00);

        // random mix
        for (int i = 0; i < 3000; i++) begin
            int r;
            logic [7:0] d;
            r = int'($urandom % 10);
            d = 8'($urandom);
            if (d[4] && ($urandom % 6 != 0)) d[4] = 1'b0;
            if (r < 2)      step(0, 1, 1'($urandom), 8'h00);
            else if (r < 5) step(1, 0, 1, d);
            else if (r < 9) step(1, 0, 0, d);
            else            step(1, 1, 1'($urandom), d);
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule